// File: doc/BRIEF.md
# Two-Stage Best-Four Candidate Sorter

This block takes in sixteen track candidates on every bunch crossing and keeps the four strongest. Four regional sources each supply four candidates. Sources 0 and 1 cover the barrel and sources 2 and 3 cover the forward region. Every candidate arrives with an 8-bit rank, which is computed upstream, a cancel flag raised by the duplicate-removal logic upstream, and a 26-bit payload made of its coordinate and quality fields.

The first stage keeps the best four barrel candidates and, separately, the best four forward candidates. The second stage merges those eight and keeps the overall best four. These are presented with the strongest first. The block is a fixed three-clock pipeline that accepts a fresh crossing on every clock. A crossing-valid flag travels alongside the data.

Top module: `bestFourSorter`

## Requirements
- R1: `outValid` equals the value `inValid` had three rising clock edges earlier, so latency is exactly three clocks.
- R2: The filled output slots hold the highest-ranked live candidates of the crossing. Slot 0 holds the highest rank, and rank never increases from slot to slot.
- R3: A candidate whose `inCancel` bit is set never appears on the output, whatever its rank.
- R4: A candidate of rank zero counts as empty. It never appears on the output, and every filled slot carries a non-zero rank.
- R5: Between equal ranks, the lower candidate index wins. Index k = source*4 + position, so barrel indices 0..7 come before forward indices 8..15.
- R6: An empty output slot has its valid bit low and drives rank and payload as all-zero. Filled slots are contiguous from slot 0.
- R7: A new crossing is accepted on every clock. Back-to-back crossings are sorted independently.
- R8: A crossing presented with `inValid` low produces, three clocks later, `outValid` low and no filled slot.
- R9: While reset is asserted, and at the first edge after it is released, `outValid`, all slot valids, ranks and payloads are zero. A crossing in flight when reset is asserted is dropped.
- R10: A candidate's 26-bit payload passes unchanged. Its layout is phi [25:18], eta [17:12], pT [11:7], charge/sync [6:5], quality [4:2], MIP [1], isolation [0].
- R11: The number of filled slots equals the smaller of 4 and the number of live candidates. A live candidate is one with non-zero rank and a clear cancel bit, in a valid crossing.
- R12: All four outputs may come from a single region. Splitting the sort by region never changes the result compared with a single sort over all sixteen candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | The candidate set on the inputs is a real crossing |
| inRank | input | 128 | Rank of candidate k at bits [k*8 +: 8] |
| inCancel | input | 16 | Duplicate flag of candidate k at bit k |
| inPayload | input | 416 | Payload of candidate k at bits [k*26 +: 26] |
| outValid | output | 1 | Output slots belong to a valid crossing |
| outSlotValid | output | 4 | Slot s holds a candidate |
| outRank | output | 32 | Rank of slot s at bits [s*8 +: 8] |
| outPayload | output | 104 | Payload of slot s at bits [s*26 +: 26] |

## Verification
The assertions assume that the inputs carry defined values on every clock after reset, including on crossings with `inValid` low. They do not constrain rank or cancel values, because the block must cope with any combination of them. The stimulus drives every input from known patterns and forces rank, cancel and payload to zero between directed crossings. This keeps the live-candidate count that the checker derives from the ports meaningful on every cycle.

// File: rtl/bestFourPkg.sv
package bestFourPkg;

  localparam int PHI_W  = 8;
  localparam int ETA_W  = 6;
  localparam int PT_W   = 5;
  localparam int CHG_W  = 2;
  localparam int QUAL_W = 3;
  localparam int PAY_W  = PHI_W + ETA_W + PT_W + CHG_W + QUAL_W + 2;

  // Payload layout, most significant field first.
  typedef struct packed {
    logic [PHI_W-1:0]  phi;
    logic [ETA_W-1:0]  eta;
    logic [PT_W-1:0]   pt;
    logic [CHG_W-1:0]  chg;
    logic [QUAL_W-1:0] qual;
    logic              mip;
    logic              iso;
  } candPayload_t;

  // Per-stage load strobes from control to datapath; a low strobe empties the stage.
  typedef struct packed {
    logic take0;
    logic take1;
    logic take2;
  } stageStrobe_t;

endpackage

// File: rtl/bestSelect.sv
// Combinational top-K selection out of N candidates by place counting.
// Each candidate's place is the number of candidates that beat it; a
// candidate beats another on higher key, or equal key and lower index.
module bestSelect #(
  parameter int N  = 8,
  parameter int K  = 4,
  parameter int RW = 8,
  parameter int PW = 26
) (
  input  logic [N*RW-1:0] rankIn,
  input  logic [N-1:0]    liveIn,
  input  logic [N*PW-1:0] payIn,
  output logic [K*RW-1:0] rankOut,
  output logic [K-1:0]    liveOut,
  output logic [K*PW-1:0] payOut
);

  localparam int CW = $clog2(N + 1);

  logic [RW:0]   key   [N];
  logic [CW-1:0] place [N];

  // Live candidates get a leading one so an empty slot can never win.
  for (genvar i = 0; i < N; i++) begin : g_key
    assign key[i] = liveIn[i] ? {1'b1, rankIn[i*RW +: RW]} : '0;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      place[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && ((key[j] > key[i]) || (key[j] == key[i] && j < i))) begin
          place[i] = place[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rankOut = '0;
    liveOut = '0;
    payOut  = '0;
    for (int s = 0; s < K; s++) begin
      for (int i = 0; i < N; i++) begin
        if (place[i] == CW'(s) && liveIn[i]) begin
          liveOut[s]            = 1'b1;
          rankOut[s*RW +: RW]   = rankIn[i*RW +: RW];
          payOut[s*PW +: PW]    = payIn[i*PW +: PW];
        end
      end
    end
  end

endmodule

// File: rtl/bestFourCtrl.sv
// Valid pipeline; hands one load strobe per stage to the datapath.
module bestFourCtrl
  import bestFourPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);

  localparam int STAGES = 3;

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[STAGES-2:0], inValid};
    end
  end

  always_comb begin
    strobe.take0 = inValid;
    strobe.take1 = validPipe[0];
    strobe.take2 = validPipe[1];
  end

  assign outValid = validPipe[STAGES-1];

endmodule

// File: rtl/bestFourPath.sv
// Three registered stages: input capture with masking, per-region best
// four, merged best four.
module bestFourPath
  import bestFourPkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int PER_SRC  = 4,
  parameter int NUM_BEST = 4,
  parameter int RANK_W   = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  stageStrobe_t                        strobe,
  input  logic [NUM_SRC*PER_SRC*RANK_W-1:0]   inRank,
  input  logic [NUM_SRC*PER_SRC-1:0]          inCancel,
  input  logic [NUM_SRC*PER_SRC*PAY_W-1:0]    inPayload,
  output logic [NUM_BEST-1:0]                 outSlotValid,
  output logic [NUM_BEST*RANK_W-1:0]          outRank,
  output logic [NUM_BEST*PAY_W-1:0]           outPayload
);

  localparam int TOTAL    = NUM_SRC * PER_SRC;
  localparam int REGIONS  = 2;
  localparam int REGION_N = TOTAL / REGIONS;
  localparam int MERGE_N  = REGIONS * NUM_BEST;

  // Stage 0: captured crossing, cancelled or zero-rank slots marked empty.
  logic [TOTAL*RANK_W-1:0] s0Rank;
  logic [TOTAL-1:0]        s0Live;
  logic [TOTAL*PAY_W-1:0]  s0Pay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0Rank <= '0;
      s0Live <= '0;
      s0Pay  <= '0;
    end else if (strobe.take0) begin
      for (int k = 0; k < TOTAL; k++) begin
        s0Live[k]                  <= !inCancel[k] && (inRank[k*RANK_W +: RANK_W] != '0);
        s0Rank[k*RANK_W +: RANK_W] <= inCancel[k] ? '0 : inRank[k*RANK_W +: RANK_W];
      end
      s0Pay <= inPayload;
    end else begin
      s0Rank <= '0;
      s0Live <= '0;
      s0Pay  <= '0;
    end
  end

  // Stage 1: best four per region (barrel = lower half of the indices).
  logic [MERGE_N*RANK_W-1:0] regRank;
  logic [MERGE_N-1:0]        regLive;
  logic [MERGE_N*PAY_W-1:0]  regPay;

  for (genvar r = 0; r < REGIONS; r++) begin : g_region
    bestSelect #(
      .N (REGION_N),
      .K (NUM_BEST),
      .RW(RANK_W),
      .PW(PAY_W)
    ) u_regionSel (
      .rankIn (s0Rank [r*REGION_N*RANK_W +: REGION_N*RANK_W]),
      .liveIn (s0Live [r*REGION_N        +: REGION_N]),
      .payIn  (s0Pay  [r*REGION_N*PAY_W  +: REGION_N*PAY_W]),
      .rankOut(regRank[r*NUM_BEST*RANK_W +: NUM_BEST*RANK_W]),
      .liveOut(regLive[r*NUM_BEST        +: NUM_BEST]),
      .payOut (regPay [r*NUM_BEST*PAY_W  +: NUM_BEST*PAY_W])
    );
  end

  logic [MERGE_N*RANK_W-1:0] s1Rank;
  logic [MERGE_N-1:0]        s1Live;
  logic [MERGE_N*PAY_W-1:0]  s1Pay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Rank <= '0;
      s1Live <= '0;
      s1Pay  <= '0;
    end else if (strobe.take1) begin
      s1Rank <= regRank;
      s1Live <= regLive;
      s1Pay  <= regPay;
    end else begin
      s1Rank <= '0;
      s1Live <= '0;
      s1Pay  <= '0;
    end
  end

  // Stage 2: merge; barrel results sit at the lower indices so ties keep
  // the global lower-index order.
  logic [NUM_BEST*RANK_W-1:0] mergeRank;
  logic [NUM_BEST-1:0]        mergeLive;
  logic [NUM_BEST*PAY_W-1:0]  mergePay;

  bestSelect #(
    .N (MERGE_N),
    .K (NUM_BEST),
    .RW(RANK_W),
    .PW(PAY_W)
  ) u_mergeSel (
    .rankIn (s1Rank),
    .liveIn (s1Live),
    .payIn  (s1Pay),
    .rankOut(mergeRank),
    .liveOut(mergeLive),
    .payOut (mergePay)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSlotValid <= '0;
      outRank      <= '0;
      outPayload   <= '0;
    end else if (strobe.take2) begin
      outSlotValid <= mergeLive;
      outRank      <= mergeRank;
      outPayload   <= mergePay;
    end else begin
      outSlotValid <= '0;
      outRank      <= '0;
      outPayload   <= '0;
    end
  end

endmodule

// File: rtl/bestFourSorter.sv
module bestFourSorter
  import bestFourPkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int PER_SRC  = 4,
  parameter int NUM_BEST = 4,
  parameter int RANK_W   = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic [NUM_SRC*PER_SRC*RANK_W-1:0] inRank,
  input  logic [NUM_SRC*PER_SRC-1:0]        inCancel,
  input  logic [NUM_SRC*PER_SRC*PAY_W-1:0]  inPayload,
  output logic                              outValid,
  output logic [NUM_BEST-1:0]               outSlotValid,
  output logic [NUM_BEST*RANK_W-1:0]        outRank,
  output logic [NUM_BEST*PAY_W-1:0]         outPayload
);

  stageStrobe_t strobe;

  bestFourCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  bestFourPath #(
    .NUM_SRC (NUM_SRC),
    .PER_SRC (PER_SRC),
    .NUM_BEST(NUM_BEST),
    .RANK_W  (RANK_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inRank      (inRank),
    .inCancel    (inCancel),
    .inPayload   (inPayload),
    .outSlotValid(outSlotValid),
    .outRank     (outRank),
    .outPayload  (outPayload)
  );

endmodule

// File: rtl/bestFourChecker.sv
module bestFourChecker
  import bestFourPkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int PER_SRC  = 4,
  parameter int NUM_BEST = 4,
  parameter int RANK_W   = 8
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              inValid,
  input logic [NUM_SRC*PER_SRC*RANK_W-1:0] inRank,
  input logic [NUM_SRC*PER_SRC-1:0]        inCancel,
  input logic                              outValid,
  input logic [NUM_BEST-1:0]               outSlotValid,
  input logic [NUM_BEST*RANK_W-1:0]        outRank,
  input logic [NUM_BEST*PAY_W-1:0]         outPayload
);

  localparam int TOTAL = NUM_SRC * PER_SRC;
  localparam int CNT_W = $clog2(NUM_BEST + 1);

  logic [CNT_W-1:0] liveNow;
  logic [2:0]       validHist;
  logic [CNT_W-1:0] cntHist [3];

  always_comb begin
    int n;
    n = 0;
    for (int k = 0; k < TOTAL; k++) begin
      if (inValid && !inCancel[k] && inRank[k*RANK_W +: RANK_W] != '0) n++;
    end
    liveNow = CNT_W'((n > NUM_BEST) ? NUM_BEST : n);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validHist <= '0;
      for (int i = 0; i < 3; i++) cntHist[i] <= '0;
    end else begin
      validHist  <= {validHist[1:0], inValid};
      cntHist[0] <= liveNow;
      cntHist[1] <= cntHist[0];
      cntHist[2] <= cntHist[1];
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == validHist[2]); // R1

  AST_FILL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outSlotValid) == int'(cntHist[2])); // R11

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> outSlotValid == '0); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outSlotValid == '0 && outPayload == '0)); // R9

  for (genvar s = 0; s < NUM_BEST; s++) begin : g_slot
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !outSlotValid[s] |-> (outRank[s*RANK_W +: RANK_W] == '0 &&
                            outPayload[s*PAY_W +: PAY_W] == '0)); // R6
    AST_RANK_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
      outSlotValid[s] |-> outRank[s*RANK_W +: RANK_W] != '0); // R4
    if (s < NUM_BEST - 1) begin : g_pair
      AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rstN)
        outSlotValid[s+1] |-> outSlotValid[s]); // R6
      AST_ORDER: assert property (@(posedge clk) disable iff (!rstN)
        outSlotValid[s+1] |-> outRank[s*RANK_W +: RANK_W] >= outRank[(s+1)*RANK_W +: RANK_W]); // R2
    end
  end

endmodule

bind bestFourSorter bestFourChecker #(
  .NUM_SRC (NUM_SRC),
  .PER_SRC (PER_SRC),
  .NUM_BEST(NUM_BEST),
  .RANK_W  (RANK_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inRank      (inRank),
  .inCancel    (inCancel),
  .outValid    (outValid),
  .outSlotValid(outSlotValid),
  .outRank     (outRank),
  .outPayload  (outPayload)
);

// File: tb/test_bestFourSorter.sv
module test_bestFourSorter;
  import bestFourPkg::*;

  localparam int NB    = 4;
  localparam int RW    = 8;
  localparam int TOTAL = 16;
  localparam int NV    = 10;

  typedef struct packed {
    logic [TOTAL-1:0] cancel;
    logic             valid;
    logic [3:0]       req;
  } vec_t;

  // Rank patterns per row come from rankOf(); this table holds the rest.
  localparam vec_t VEC [NV] = '{
    '{16'h0000, 1'b1, 4'd12},  // 0: ascending, forward wins all (R12)
    '{16'h0000, 1'b1, 4'd12},  // 1: descending, barrel wins all (R12)
    '{16'h0000, 1'b1, 4'd5},   // 2: all equal ranks (R5)
    '{16'h0000, 1'b1, 4'd5},   // 3: ties across regions (R5)
    '{16'hC000, 1'b1, 4'd3},   // 4: two best cancelled (R3)
    '{16'h0000, 1'b1, 4'd4},   // 5: mostly zero rank (R4, R11)
    '{16'h0000, 1'b0, 4'd8},   // 6: crossing not valid (R8)
    '{16'hFFFF, 1'b1, 4'd3},   // 7: everything cancelled (R3)
    '{16'h0004, 1'b1, 4'd2},   // 8: mixed ranks (R2)
    '{16'h0000, 1'b1, 4'd5}    // 9: tie at the region boundary (R5)
  };

  logic                clk;
  logic                rstN;
  logic                inValid;
  logic [TOTAL*RW-1:0] inRank;
  logic [TOTAL-1:0]    inCancel;
  logic [TOTAL*PAY_W-1:0] inPayload;
  logic                outValid;
  logic [NB-1:0]       outSlotValid;
  logic [NB*RW-1:0]    outRank;
  logic [NB*PAY_W-1:0] outPayload;

  int checks;
  int failures;
  bit done;

  bestFourSorter i_bestFourSorter (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inRank      (inRank),
    .inCancel    (inCancel),
    .inPayload   (inPayload),
    .outValid    (outValid),
    .outSlotValid(outSlotValid),
    .outRank     (outRank),
    .outPayload  (outPayload)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  function automatic logic [RW-1:0] rankOf(int v, int k);
    case (v)
      0, 4, 6: return RW'(k + 1);
      1:       return RW'(100 - k);
      2:       return 8'd50;
      3:       return (k == 3 || k == 6 || k == 9) ? 8'd200 : 8'd10;
      5:       return (k == 5) ? 8'd7 : (k == 12) ? 8'd9 : 8'd0;
      7:       return 8'd77;
      8:       return (k == 2 || k == 8) ? 8'd255 : (k == 1) ? 8'd254 :
                      (k == 14 || k == 7) ? 8'd128 : 8'd1;
      9:       return (k == 0 || k == 7 || k == 8 || k == 12) ? 8'd90 : 8'd20;
      default: return 8'd0;
    endcase
  endfunction

  function automatic candPayload_t payFor(int v, int k);
    candPayload_t p;
    p.phi  = 8'(v * 16 + k);
    p.eta  = 6'(k);
    p.pt   = 5'(v);
    p.chg  = 2'(k);
    p.qual = 3'(v);
    p.mip  = k[0];
    p.iso  = v[0];
    return p;
  endfunction

  task automatic applyVec(int v);
    inValid  = VEC[v].valid;
    inCancel = VEC[v].cancel;
    for (int k = 0; k < TOTAL; k++) begin
      inRank[k*RW +: RW]          = rankOf(v, k);
      inPayload[k*PAY_W +: PAY_W] = payFor(v, k);
    end
  endtask

  task automatic idle();
    inValid   = 1'b0;
    inRank    = '0;
    inCancel  = '0;
    inPayload = '0;
  endtask

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference: repeatedly take the highest live rank, first index on ties.
  task automatic expectVec(int v, output logic [NB-1:0] eV,
                           output logic [NB*RW-1:0] eR, output logic [NB*PAY_W-1:0] eP);
    bit taken [TOTAL];
    eV = '0;
    eR = '0;
    eP = '0;
    for (int k = 0; k < TOTAL; k++) taken[k] = 1'b0;
    for (int s = 0; s < NB; s++) begin
      int best;
      best = -1;
      if (VEC[v].valid) begin
        for (int k = 0; k < TOTAL; k++) begin
          if (!taken[k] && !VEC[v].cancel[k] && rankOf(v, k) != 0 &&
              (best < 0 || rankOf(v, k) > rankOf(v, best))) best = k;
        end
      end
      if (best >= 0) begin
        taken[best]            = 1'b1;
        eV[s]                  = 1'b1;
        eR[s*RW +: RW]         = rankOf(v, best);
        eP[s*PAY_W +: PAY_W]   = payFor(v, best);
      end
    end
  endtask

  initial begin
    logic [NB-1:0]       eV;
    logic [NB*RW-1:0]    eR;
    logic [NB*PAY_W-1:0] eP;
    string               tag;
    int                  v;
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rstN     = 1'b0;
    idle();

    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset outValid", 128'(outValid), 128'(0));
    check("R9 reset slots", 128'(outSlotValid), 128'(0));
    check("R9 reset rank", 128'(outRank), 128'(0));
    check("R9 reset payload", 128'(outPayload), 128'(0));
    rstN = 1'b1;

    // Table: one crossing per clock, back to back (R7), outputs 3 clocks later.
    for (int c = 0; c < NV + 3; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        v = c - 3;
        expectVec(v, eV, eR, eP);
        tag = $sformatf("R%0d row%0d", VEC[v].req, v);
        check({tag, " R1 outValid"}, 128'(outValid), 128'(VEC[v].valid));
        check({tag, " R7 slots"}, 128'(outSlotValid), 128'(eV));
        check({tag, " rank"}, 128'(outRank), 128'(eR));
        check({tag, " payload"}, 128'(outPayload), 128'(eP));
      end
      if (c < NV) applyVec(c);
      else idle();
    end

    // R1: a single crossing appears exactly on the third clock.
    @(negedge clk);
    applyVec(1);
    for (int d = 1; d <= 4; d++) begin
      @(negedge clk);
      if (d == 1) idle();
      check($sformatf("R1 latency d=%0d", d), 128'(outValid), 128'(d == 3));
      if (d == 3) begin
        expectVec(1, eV, eR, eP);
        check("R1 latency payload", 128'(outPayload), 128'(eP));
      end
    end

    // R10 / R4 / R3: all-ones payload of the only live candidate passes
    // intact; a zero-rank and a cancelled candidate stay out.
    @(negedge clk);
    inValid = 1'b1;
    inRank[3*RW +: RW]            = 8'd1;
    inPayload[3*PAY_W +: PAY_W]   = '1;
    inPayload[10*PAY_W +: PAY_W]  = 26'h155_5555;
    inRank[5*RW +: RW]            = 8'd200;
    inCancel[5]                   = 1'b1;
    inPayload[5*PAY_W +: PAY_W]   = 26'h2AA_AAAA;
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    check("R4 single live slot", 128'(outSlotValid), 128'(4'b0001));
    check("R10 payload intact", 128'(outPayload[PAY_W-1:0]), 128'({PAY_W{1'b1}}));
    check("R3 cancelled absent", 128'(outRank), 128'(1));
    check("R6 empty slots zero", 128'(outPayload[NB*PAY_W-1:PAY_W]), 128'(0));

    // R9: crossings in flight when reset hits are dropped.
    @(negedge clk);
    applyVec(0);
    @(negedge clk);
    applyVec(1);
    @(negedge clk);
    rstN = 1'b0;
    idle();
    @(negedge clk);
    check("R9 midrun outValid", 128'(outValid), 128'(0));
    check("R9 midrun slots", 128'(outSlotValid), 128'(0));
    rstN = 1'b1;
    for (int d = 1; d <= 3; d++) begin
      @(negedge clk);
      check($sformatf("R9 dropped d=%0d", d), 128'(outValid), 128'(0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule